// File: doc/BRIEF.md
# Program Flow Sequencer

This block owns the program counter of a small 18-bit-instruction processor. In every cycle it takes the instruction fetched from the current address and the four condition flags (zero, carry, negative, overflow), and it computes the next fetch address. An instruction either steps forward by one, loads an absolute target, calls a subroutine, returns from one, or branches relative to itself when a condition holds. Instructions whose two top bits are not both set belong to the datapath, and here they only advance the counter.

Return addresses are held in a small circular stack inside the block. Program instructions cannot read or write it. A call made while the stack is full overwrites the oldest entry and raises an overflow pulse. A return made while the stack is empty falls through to the next address and raises an underflow pulse. A return word whose low fourteen bits are not all zero is malformed. It is flagged, and it then acts as a plain sequential step.

All outputs are registered. Each status pulse is high for exactly the one cycle in which the fetch address that follows the offending instruction is presented.

Top module: `flow_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active-high), `fetch_addr` becomes 0, all three status pulses become 0, and the return stack is emptied.
- R2: An instruction with bits 17:16 other than `11` makes the next `fetch_addr` equal to the current one plus 1, modulo 2^AW (0x3FFF wraps to 0).
- R3: An instruction with bits 17:14 = `1110` (jump) loads bits 13:0 into `fetch_addr` on the next cycle.
- R4: An instruction with bits 17:14 = `1101` (call) loads bits 13:0 into `fetch_addr` and pushes the current address plus 1 onto the return stack.
- R5: An instruction with bits 17:14 = `1100` and bits 13:0 all zero (return) sets `fetch_addr` to the most recently pushed address that has not been popped yet, in last-in first-out order.
- R6: An instruction with bits 17:14 = `1111` (branch) reads its condition from bits 13:11. When the condition holds, the next address is the current address plus 1 plus bits 10:0 taken as a two's-complement offset, modulo 2^AW. When it does not hold, the next address is the current address plus 1.
- R7: The branch conditions are: 000 Z=1, 001 Z=0, 010 C=1, 011 C=0, 100 N=1, 101 N=0, 110 (N xor V)=1 (signed less than), 111 (N xor V)=0 (signed greater or equal).
- R8: The stack holds DEPTH entries (default 8). A call made with DEPTH entries held overwrites the oldest entry, keeps the count at DEPTH, and drives `stack_ovf` high for the next cycle. Otherwise `stack_ovf` is low.
- R9: A return made with the stack empty leaves the stack empty, advances `fetch_addr` by 1, and drives `stack_unf` high for the next cycle. Otherwise `stack_unf` is low.
- R10: A word with bits 17:14 = `1100` and any nonzero bit in 13:0 does not touch the stack, advances `fetch_addr` by 1, and drives `ret_illegal` high for the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 18 | Instruction fetched from `fetch_addr` |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Signed overflow flag |
| fetch_addr | output | AW (14) | Registered program counter / next fetch address |
| stack_ovf | output | 1 | One-cycle pulse: call overwrote the oldest return entry |
| stack_unf | output | 1 | One-cycle pulse: return issued with an empty stack |
| ret_illegal | output | 1 | One-cycle pulse: malformed return word seen |

## Verification
Two events can fall in the same cycle: a call issued at full depth both redirects the counter and evicts the oldest return entry. A return issued on an empty stack both falls through and signals underflow. The bench provokes the first with nine nested calls and the second with nine returns that follow them. A behavioural queue model predicts both the address sequence and the exact cycle of each pulse. The model drops its front element when it grows past eight, and it flags a pop from an empty queue. The bench compares the address and all three pulses with the model after every clock. This shows that the eviction and the underflow neither disturb the redirection nor leave a stale entry behind.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int INSTR_W = 18;
  localparam int TGT_W   = 14;
  localparam int OFS_W   = 11;

  typedef enum logic [2:0] {
    K_SEQ,
    K_JUMP,
    K_CALL,
    K_RET,
    K_BADRET,
    K_BRANCH
  } kind_t;

  typedef enum logic [2:0] {
    C_ZSET  = 3'b000,
    C_ZCLR  = 3'b001,
    C_CSET  = 3'b010,
    C_CCLR  = 3'b011,
    C_NSET  = 3'b100,
    C_NCLR  = 3'b101,
    C_SLT   = 3'b110,
    C_SGE   = 3'b111
  } cond_t;
endpackage

// File: rtl/flow_cond.sv
module flow_cond
  import flow_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       z,
  input  logic       c,
  input  logic       n,
  input  logic       v,
  output logic       take
);
  logic lt;
  assign lt = n ^ v;

  always_comb begin
    case (cond_t'(cond))
      C_ZSET:  take = z;
      C_ZCLR:  take = ~z;
      C_CSET:  take = c;
      C_CCLR:  take = ~c;
      C_NSET:  take = n;
      C_NCLR:  take = ~n;
      C_SLT:   take = lt;
      default: take = ~lt;
    endcase
  end
endmodule

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               z,
  input  logic               c,
  input  logic               n,
  input  logic               v,
  output kind_t              kind,
  output logic [AW-1:0]      target,
  output logic [AW-1:0]      rel,
  output logic               take
);
  logic [3:0] major;
  assign major  = instr[INSTR_W-1 -: 4];
  assign target = AW'(instr[TGT_W-1:0]);
  assign rel    = AW'($signed(instr[OFS_W-1:0]));

  flow_cond u_cond (
    .cond (instr[TGT_W-1 -: 3]),
    .z    (z),
    .c    (c),
    .n    (n),
    .v    (v),
    .take (take)
  );

  always_comb begin
    case (major)
      4'b1100: kind = (instr[TGT_W-1:0] == '0) ? K_RET : K_BADRET;
      4'b1101: kind = K_CALL;
      4'b1110: kind = K_JUMP;
      4'b1111: kind = K_BRANCH;
      default: kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/flow_retstack.sv
module flow_retstack #(
  parameter int AW    = 14,
  parameter int DEPTH = 8   // power of two: the pointer wraps naturally
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp;
  logic [PW:0]   cnt;
  logic [PW-1:0] sp_top;

  assign sp_top   = sp - 1'b1;
  assign top_data = mem[sp_top];
  assign empty    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= push && (cnt == FULL);
      unf <= pop && empty;
      if (push) begin
        sp <= sp + 1'b1;
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end else if (pop && !empty) begin
        sp  <= sp_top;
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  assert_ovf_on_full_R8: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == FULL) |=> (ovf && cnt == FULL));
  assert_no_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    (!push) |=> !ovf);
  assert_unf_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == '0) |=> (unf && cnt == '0));
  assert_pop_count_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import flow_pkg::*;
#(
  parameter int AW    = 14,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag_z,
  input  logic               flag_c,
  input  logic               flag_n,
  input  logic               flag_v,
  output logic [AW-1:0]      fetch_addr,
  output logic               stack_ovf,
  output logic               stack_unf,
  output logic               ret_illegal
);
  kind_t         kind;
  logic [AW-1:0] target, rel, pc_inc, top_data, pc_next;
  logic          take, empty, push, pop;

  flow_decode #(.AW(AW)) u_dec (
    .instr  (instr),
    .z      (flag_z),
    .c      (flag_c),
    .n      (flag_n),
    .v      (flag_v),
    .kind   (kind),
    .target (target),
    .rel    (rel),
    .take   (take)
  );

  assign pc_inc = fetch_addr + 1'b1;
  assign push   = (kind == K_CALL);
  assign pop    = (kind == K_RET);

  flow_retstack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (pc_inc),
    .top_data  (top_data),
    .empty     (empty),
    .ovf       (stack_ovf),
    .unf       (stack_unf)
  );

  always_comb begin
    case (kind)
      K_JUMP, K_CALL: pc_next = target;
      K_RET:          pc_next = empty ? pc_inc : top_data;
      K_BRANCH:       pc_next = take ? (pc_inc + rel) : pc_inc;
      default:        pc_next = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr  <= '0;
      ret_illegal <= 1'b0;
    end else begin
      fetch_addr  <= pc_next;
      ret_illegal <= (kind == K_BADRET);
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0 && !ret_illegal));
  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (instr[17:16] != 2'b11) |=> (fetch_addr == $past(fetch_addr) + 1'b1));
  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (instr[17:14] == 4'b1110) |=> (fetch_addr == AW'($past(instr[13:0]))));
  assert_call_R4: assert property (@(posedge clk) disable iff (rst)
    (instr[17:14] == 4'b1101) |=> (fetch_addr == AW'($past(instr[13:0]))));
  assert_badret_R10: assert property (@(posedge clk) disable iff (rst)
    (instr[17:14] == 4'b1100 && instr[13:0] != '0)
      |=> (ret_illegal && fetch_addr == $past(fetch_addr) + 1'b1));
endmodule

// File: tb/tb_flow_sequencer.sv
module tb_flow_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] instr = '0;
  logic        fz = 0, fc = 0, fn = 0, fv = 0;
  logic [13:0] fetch_addr;
  logic        stack_ovf, stack_unf, ret_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_pc = 0;
  int stk[$];

  always #10 clk = ~clk;  // 50 MHz

  flow_sequencer dut (
    .clk(clk), .rst(rst), .instr(instr),
    .flag_z(fz), .flag_c(fc), .flag_n(fn), .flag_v(fv),
    .fetch_addr(fetch_addr), .stack_ovf(stack_ovf),
    .stack_unf(stack_unf), .ret_illegal(ret_illegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] op_jmp(input int a);  return {4'b1110, 14'(a)}; endfunction
  function automatic logic [17:0] op_call(input int a); return {4'b1101, 14'(a)}; endfunction
  function automatic logic [17:0] op_ret();             return {4'b1100, 14'h0};  endfunction
  function automatic logic [17:0] op_br(input int cnd, input int ofs);
    return {4'b1111, 3'(cnd), 11'(ofs)};
  endfunction

  // flags packed as {z,c,n,v}
  task automatic step(input logic [17:0] ins, input logic [3:0] f, input string tag);
    int nxt, ofs;
    bit take, e_ovf, e_unf, e_bad;
    instr = ins;
    {fz, fc, fn, fv} = f;
    e_ovf = 0; e_unf = 0; e_bad = 0;
    nxt = (m_pc + 1) & 16'h3FFF;
    if (ins[17:16] == 2'b11) begin
      case (ins[15:14])
        2'b00: begin
          if (ins[13:0] != 0) e_bad = 1;
          else if (stk.size() == 0) e_unf = 1;
          else nxt = stk.pop_back();
        end
        2'b01: begin
          stk.push_back(nxt);
          if (stk.size() > 8) begin void'(stk.pop_front()); e_ovf = 1; end
          nxt = int'(ins[13:0]);
        end
        2'b10: nxt = int'(ins[13:0]);
        default: begin
          case (ins[13:11])
            3'd0: take = f[3];
            3'd1: take = !f[3];
            3'd2: take = f[2];
            3'd3: take = !f[2];
            3'd4: take = f[1];
            3'd5: take = !f[1];
            3'd6: take = f[1] != f[0];
            default: take = f[1] == f[0];
          endcase
          ofs = ins[10] ? int'(ins[10:0]) - 2048 : int'(ins[10:0]);
          if (take) nxt = (m_pc + 1 + ofs) & 16'h3FFF;
        end
      endcase
    end
    @(negedge clk);
    m_pc = nxt;
    chk(tag, int'(fetch_addr), m_pc);
    chk("R8 ovf", int'(stack_ovf), int'(e_ovf));
    chk("R9 unf", int'(stack_unf), int'(e_unf));
    chk("R10 illegal", int'(ret_illegal), int'(e_bad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc", int'(fetch_addr), 0);
    chk("R1 flags", int'({stack_ovf, stack_unf, ret_illegal}), 0);
    rst = 1'b0;

    // R2: datapath words only advance
    step(18'h00000, 4'b0000, "R2 seq");
    step(18'h1ABCD, 4'b1111, "R2 seq");
    step(18'h2FFFF, 4'b1010, "R2 seq");
    // R3: jump, then wrap at top of space (R2)
    step(op_jmp(14'h3FFE), 4'b0000, "R3 jump");
    step(18'h00001, 4'b0000, "R2 seq");
    step(18'h00001, 4'b0000, "R2 wrap");
    step(op_jmp(14'h0100), 4'b0000, "R3 jump");

    // R6/R7: every condition, held and not held
    for (int cd = 0; cd < 8; cd++) begin
      for (int fl = 0; fl < 16; fl++) begin
        step(op_br(cd, (fl[0] ? -5 : 9)), 4'(fl), "R7 cond");
      end
    end
    step(op_br(0, -1024), 4'b1000, "R6 back");
    step(op_br(1, 1023), 4'b0000, "R6 fwd");
    step(op_jmp(14'h0005), 4'b0000, "R3 jump");
    step(op_br(0, -20), 4'b1000, "R6 wrap");

    // R4/R5: nested calls and returns
    step(op_call(14'h0200), 4'b0000, "R4 call");
    step(18'h00000, 4'b0000, "R2 seq");
    step(op_call(14'h0300), 4'b0000, "R4 call");
    step(op_call(14'h0400), 4'b0000, "R4 call");
    step(op_ret(), 4'b0000, "R5 ret");
    step(18'h00000, 4'b0000, "R2 seq");
    step(op_ret(), 4'b0000, "R5 ret");
    // R10: malformed return leaves stack alone
    step({4'b1100, 14'h0001}, 4'b0000, "R10 badret");
    step({4'b1100, 14'h2000}, 4'b0000, "R10 badret");
    step(op_ret(), 4'b0000, "R5 ret");
    // R9: underflow on empty stack
    step(op_ret(), 4'b0000, "R9 underflow");

    // R8: nine calls overflow, then nine returns
    for (int i = 0; i < 9; i++) step(op_call(14'h1000 + 16*i), 4'b0000, "R8 call");
    for (int i = 0; i < 9; i++) step(op_ret(), 4'b0000, "R8 ret");
    step(op_ret(), 4'b0000, "R9 underflow");

    // R1: reset mid-run clears pc and stack
    step(op_call(14'h0777), 4'b0000, "R4 call");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0;
    stk.delete();
    chk("R1 pc", int'(fetch_addr), 0);
    step(op_ret(), 4'b0000, "R1 stack empty");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule